// File: doc/BRIEF.md
# Pipelined Fractional Strobe Generator

This block produces a one-cycle enable strobe at an average rate of the system clock rate times STEP / 2^W. STEP and W are set at build time, so the division ratio does not have to be a whole number. Internally a W-bit phase accumulator gains STEP on every clock. The strobe is the carry that falls out of the top of the accumulator. Logic elsewhere in the chip uses the strobe as a clock enable and never as a clock edge.

To keep the carry chain short, the accumulator is split into two words of HALF_W bits. The lower word adds its share of the step and registers its own carry. The upper word picks up that registered carry one cycle later. A one-cycle delayed copy of the lower word, placed next to the upper word, gives a full-width count whose two halves describe the same instant. That count trails the ideal accumulator by exactly one cycle. The top bit of the upper word is also brought out as a roughly square divided clock, meant for external pins only.

Top module: `frac_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `stb_o`, `count_o` and `clk_div_o` are all zero.
- R2: Let n be the number of rising edges since reset was released. For n >= 1, `count_o` equals ((n-1) * STEP) mod 2^W, where STEP = {HIGH_STEP, LOW_STEP}. For n = 0, `count_o` is 0.
- R3: `stb_o` is high after edge n (n >= 2) exactly when floor((n-1)*STEP / 2^W) > floor((n-2)*STEP / 2^W). This is the same as the aligned count wrapping below its previous value. `stb_o` is low at n = 0 and at n = 1.
- R4: Across the 2^W consecutive cycles n = 2 to 2^W + 1, the number of strobes is exactly STEP.
- R5: Each gap between two consecutive strobes is either floor(2^W / STEP) or ceil(2^W / STEP) cycles. For STEP = 0x517d with W = 16, every gap is 3 or 4 cycles.
- R6: With STEP = 0, `stb_o` never rises and `count_o` stays at 0.
- R7: `clk_div_o` always equals bit W-1 of `count_o`.
- R8: HALF_W may be any value from 1 to 24, so W can be as wide as 48 bits. A 48-bit instance follows R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_o | output | 1 | One-cycle enable strobe at each accumulator rollover |
| count_o | output | 2*HALF_W | Aligned full-width count: upper word above the delayed lower word |
| clk_div_o | output | 1 | Top accumulator bit, a divided clock for external pins |

## Verification
The checker assumes that `rst` is high from time zero through the first rising edge. Its cycle counter and its `$past` comparisons depend on that. It also assumes that the step stays fixed, which is always true because the step is a parameter. The bench holds reset from time zero for several edges and releases it on a falling edge. It then runs five instances side by side with steps that exercise different cases: a fraction near pi, zero, exactly one half, the all-ones step that carries almost every cycle, and a 48-bit mixed step.

// File: rtl/frac_strobe_pkg.sv
package frac_strobe_pkg;
    // Widest half-word the generator is built for (total accumulator 48 bits).
    localparam int unsigned FS_MAX_HALF_W = 24;
endpackage

// File: rtl/frac_lo_word.sv
module frac_lo_word #(
    parameter int unsigned HALF_W = 8,
    parameter logic [HALF_W-1:0] LOW_STEP = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              carry_o,
    output logic [HALF_W-1:0] dly_o
);
    typedef struct packed {
        logic [HALF_W-1:0] word;
        logic              carry;
        logic [HALF_W-1:0] dly;
    } lo_state_t;

    lo_state_t st_d, st_q;
    logic [HALF_W:0] sum_d;

    always_comb begin
        sum_d       = {1'b0, st_q.word} + {1'b0, LOW_STEP};
        st_d.word   = sum_d[HALF_W-1:0];
        st_d.carry  = sum_d[HALF_W];
        st_d.dly    = st_q.word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign carry_o = st_q.carry;
    assign dly_o   = st_q.dly;
endmodule

// File: rtl/frac_hi_word.sv
module frac_hi_word #(
    parameter int unsigned HALF_W = 8,
    parameter logic [HALF_W-1:0] HIGH_STEP = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              carry_i,
    output logic [HALF_W-1:0] word_o,
    output logic              stb_o
);
    typedef struct packed {
        logic [HALF_W-1:0] word;
        logic              primed;
        logic              stb;
    } hi_state_t;

    hi_state_t st_d, st_q;
    logic [HALF_W:0] sum_d;
    logic [HALF_W-1:0] add_d;

    always_comb begin
        // The upper word starts one cycle late so it lines up with the delayed lower word.
        add_d        = st_q.primed ? HIGH_STEP : '0;
        sum_d        = {1'b0, st_q.word} + {1'b0, add_d} + {{HALF_W{1'b0}}, carry_i};
        st_d.word    = sum_d[HALF_W-1:0];
        st_d.stb     = sum_d[HALF_W];
        st_d.primed  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o = st_q.word;
    assign stb_o  = st_q.stb;
endmodule

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen #(
    parameter int unsigned HALF_W = 8,
    parameter logic [HALF_W-1:0] LOW_STEP  = 8'h7d,
    parameter logic [HALF_W-1:0] HIGH_STEP = 8'h51
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic                  stb_o,
    output logic [2*HALF_W-1:0]   count_o,
    output logic                  clk_div_o
);
    localparam int unsigned W = 2 * HALF_W;

    logic              lo_carry_w;
    logic [HALF_W-1:0] lo_dly_w;
    logic [HALF_W-1:0] hi_word_w;

    frac_lo_word #(.HALF_W(HALF_W), .LOW_STEP(LOW_STEP)) lo_i (
        .clk(clk), .rst(rst), .carry_o(lo_carry_w), .dly_o(lo_dly_w)
    );

    frac_hi_word #(.HALF_W(HALF_W), .HIGH_STEP(HIGH_STEP)) hi_i (
        .clk(clk), .rst(rst), .carry_i(lo_carry_w), .word_o(hi_word_w), .stb_o(stb_o)
    );

    assign count_o   = {hi_word_w, lo_dly_w};
    assign clk_div_o = count_o[W-1];
endmodule

// File: rtl/frac_strobe_chk.sv
module frac_strobe_chk #(
    parameter int unsigned HALF_W = 8,
    parameter logic [HALF_W-1:0] LOW_STEP  = '0,
    parameter logic [HALF_W-1:0] HIGH_STEP = '0
) (
    input logic                clk,
    input logic                rst,
    input logic                stb_o,
    input logic [2*HALF_W-1:0] count_o,
    input logic                clk_div_o
);
    import frac_strobe_pkg::*;
    localparam int unsigned W = 2 * HALF_W;
    localparam logic [W-1:0] STEP = {HIGH_STEP, LOW_STEP};

    logic [1:0] cyc_d, cyc_q;
    always_comb cyc_d = (cyc_q == 2'd2) ? cyc_q : cyc_q + 2'd1;
    always_ff @(posedge clk) begin
        if (rst) cyc_q <= '0;
        else     cyc_q <= cyc_d;
    end

    initial begin
        p_width_r8: assert (HALF_W >= 1 && HALF_W <= FS_MAX_HALF_W);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!stb_o && count_o == '0 && !clk_div_o));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == 2'd2) |-> ((count_o - $past(count_o)) == STEP));

    p_stb_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == 2'd2) |-> (stb_o == (count_o < $past(count_o))));

    p_early_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc_q != 2'd2) |-> !stb_o);

    p_zero_step_r6: assert property (@(posedge clk) disable iff (rst)
        (STEP == '0) |-> (!stb_o && count_o == '0));

    p_clkdiv_msb_r7: assert property (@(posedge clk) disable iff (rst)
        clk_div_o == count_o[W-1]);
endmodule

bind frac_strobe_gen frac_strobe_chk #(
    .HALF_W(HALF_W), .LOW_STEP(LOW_STEP), .HIGH_STEP(HIGH_STEP)
) chk_i (
    .clk(clk), .rst(rst), .stb_o(stb_o), .count_o(count_o), .clk_div_o(clk_div_o)
);

// File: tb/frac_strobe_gen_tb_top.sv
module frac_strobe_gen_tb_top;
    localparam int NI   = 5;
    localparam int NCYC = 65538;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    logic [NI-1:0]        stb_w, cdiv_w;
    logic [NI-1:0][63:0]  cnt_w;
    logic [15:0] c0, c1, c2, c3;
    logic [47:0] c4;

    frac_strobe_gen #(.HALF_W(8), .LOW_STEP(8'h7d), .HIGH_STEP(8'h51)) dut_i (
        .clk(clk), .rst(rst), .stb_o(stb_w[0]), .count_o(c0), .clk_div_o(cdiv_w[0]));
    frac_strobe_gen #(.HALF_W(8), .LOW_STEP(8'h00), .HIGH_STEP(8'h00)) dut_zero_i (
        .clk(clk), .rst(rst), .stb_o(stb_w[1]), .count_o(c1), .clk_div_o(cdiv_w[1]));
    frac_strobe_gen #(.HALF_W(8), .LOW_STEP(8'h00), .HIGH_STEP(8'h80)) dut_half_i (
        .clk(clk), .rst(rst), .stb_o(stb_w[2]), .count_o(c2), .clk_div_o(cdiv_w[2]));
    frac_strobe_gen #(.HALF_W(8), .LOW_STEP(8'hff), .HIGH_STEP(8'hff)) dut_max_i (
        .clk(clk), .rst(rst), .stb_o(stb_w[3]), .count_o(c3), .clk_div_o(cdiv_w[3]));
    frac_strobe_gen #(.HALF_W(24), .LOW_STEP(24'habcdef), .HIGH_STEP(24'h123456)) dut_wide_i (
        .clk(clk), .rst(rst), .stb_o(stb_w[4]), .count_o(c4), .clk_div_o(cdiv_w[4]));

    assign cnt_w[0] = {48'd0, c0};
    assign cnt_w[1] = {48'd0, c1};
    assign cnt_w[2] = {48'd0, c2};
    assign cnt_w[3] = {48'd0, c3};
    assign cnt_w[4] = {16'd0, c4};

    logic [63:0] step_c [NI];
    int          width_c [NI];
    initial begin
        step_c[0] = 64'h517d; step_c[1] = 64'h0; step_c[2] = 64'h8000;
        step_c[3] = 64'hffff; step_c[4] = 64'h123456abcdef;
        for (int k = 0; k < 4; k++) width_c[k] = 16;
        width_c[4] = 48;
    end

    typedef struct {
        longint              n;
        logic [NI-1:0][63:0] cnt;
        logic [NI-1:0]       stb;
    } exp_t;
    exp_t sb_q[$];

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    longint strobes [NI];
    longint last_n  [NI];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] acc_at(longint n, logic [63:0] s, int w);
        logic [63:0] m;
        m = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
        if (n < 1) return 64'd0;
        return (64'(n - 1) * s) & m;
    endfunction

    // Driver: after each edge, compute expected values for that cycle and push them.
    task automatic push_expected(input longint n);
        exp_t e;
        e.n = n;
        for (int k = 0; k < NI; k++) begin
            e.cnt[k] = acc_at(n, step_c[k], width_c[k]);
            if (n >= 2 && width_c[k] == 16)
                e.stb[k] = ((64'(n - 1) * step_c[k]) >> 16) != ((64'(n - 2) * step_c[k]) >> 16);
            else
                e.stb[k] = 1'b0;
        end
        sb_q.push_back(e);
    endtask

    // Monitor: pop and compare at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            for (int k = 0; k < NI; k++) begin
                if (k == 4)      check(cnt_w[k] == e.cnt[k], "R8 wide count", cnt_w[k], e.cnt[k]);
                else if (k == 1) check(cnt_w[k] == 0 && stb_w[k] == 0, "R6 zero step", cnt_w[k], 0);
                else             check(cnt_w[k] == e.cnt[k], "R2 count", cnt_w[k], e.cnt[k]);
                if (k < 4) begin
                    check(stb_w[k] == e.stb[k], "R3 strobe", 64'(stb_w[k]), 64'(e.stb[k]));
                    check(cdiv_w[k] == cnt_w[k][width_c[k]-1], "R7 clk_div", 64'(cdiv_w[k]),
                          64'(cnt_w[k][width_c[k]-1]));
                    if (stb_w[k] && e.n >= 2 && e.n <= 65537) begin
                        strobes[k]++;
                        if (last_n[k] > 0 && step_c[k] != 0) begin
                            longint fl, ce, gap;
                            fl  = 65536 / longint'(step_c[k]);
                            ce  = (65536 + longint'(step_c[k]) - 1) / longint'(step_c[k]);
                            gap = e.n - last_n[k];
                            check(gap == fl || gap == ce, "R5 gap", 64'(gap), 64'(fl));
                        end
                        last_n[k] = e.n;
                    end
                end
            end
        end
    end

    task automatic check_reset_state(input string tag);
        for (int k = 0; k < NI; k++)
            check(stb_w[k] == 0 && cnt_w[k] == 0 && cdiv_w[k] == 0, tag, cnt_w[k], 0);
    endtask

    initial begin
        for (int k = 0; k < NI; k++) begin strobes[k] = 0; last_n[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("R1 reset state");
        rst = 1'b0;
        for (longint n = 1; n <= NCYC; n++) begin
            @(posedge clk);
            #1;
            push_expected(n);
        end
        @(negedge clk);
        // R4: strobe total over one full accumulator period equals the step.
        for (int k = 0; k < 4; k++)
            check(strobes[k] == longint'(step_c[k]), "R4 strobe total", 64'(strobes[k]), step_c[k]);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state("R1 reset mid-run");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule